// File: doc/BRIEF.md
# SCSI Controller Register Front End

This block is the byte-wide register window that a processor uses to drive a SCSI protocol controller. Sixteen registers sit at a four-byte stride, so the register index is the byte address shifted right by two. The window holds the transfer count, a configuration byte and a few free-form bytes. It also holds a sixteen-entry data FIFO and a command register whose writes start internal actions. A status, interrupt and sequence register trio reports what those actions did.

Each access is a one-cycle strobe. A read returns data in the same cycle as the strobe. The side effects of the read (a FIFO pop, or acknowledging the interrupt) take effect at the clock edge that ends the strobe. The block drives one interrupt request line. It also drives a flag toward a companion DMA engine that marks an interrupt caused by DMA activity. Bit 7 of every command byte selects DMA mode for that command and the ones that follow.

Top module: `scsi_regif`

## Requirements
- R1: After reset every register reads 0x00 except index 14, which reads 0x04. The FIFO is empty, an empty FIFO read returns 0x00, and irq, dma_irq and dma_mode are 0.
- R2: Indices 0 (low byte) and 1 (high byte) read back as written and form the 16-bit xfer_count output.
- R3: A write to index 2 appends a byte to the FIFO. A read of index 2 with the FIFO not empty returns the oldest byte, removes it and sets irq.
- R4: The FIFO holds 16 bytes. A write to index 2 while it is full is dropped, so exactly the first 16 bytes come back in order.
- R5: A read of index 2 with the FIFO empty returns the byte most recently removed (0x00 after reset) and leaves irq unchanged.
- R6: A write to index 3 stores the command byte, which reads back. Its bit 7 sets dma_mode (1) or clears it (0). Its bits 6:0 are the command code.
- R7: Code 0x01 (flush) sets index 5 to 0x08 and index 6 to 0x00, and empties the FIFO. It does not raise irq.
- R8: Code 0x02 (chip reset) restores the full R1 state, including irq, dma_irq and the stored command byte.
- R9: Code 0x03 (bus reset) sets index 5 to 0x80. It raises irq and dma_irq only when bit 6 of index 8 is 0.
- R10: Code 0x10 (transfer) with bit 7 set sets index 4 to 0x93, index 5 to 0x10 and index 6 to 0x00, and raises irq and dma_irq.
- R11: Code 0x10 with bit 7 clear makes the FIFO hold min(xfer_count,16) bytes, read from entry 0 onward. It copies the low count byte to index 7 and raises irq, but not dma_irq.
- R12: A read of index 5 returns its value, then clears every bit of index 4 except bit 4 (terminal count), and clears irq and dma_irq.
- R13: Writes to index 11 keep only the bits in 0x15. Writes to 8 and 12 to 15 are stored as written. Writes to 4 to 7, 9 and 10 do not change what those registers read.
- R14: Any other command code changes nothing except the stored command byte and, through its bit 7, dma_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access; ignored when wr_en is high |
| addr | input | ADDR_W | Byte address; bits 5:2 select the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high |
| irq | output | 1 | Interrupt request |
| dma_irq | output | 1 | DMA-related interrupt flag to the companion DMA block |
| dma_mode | output | 1 | Bit 7 of the last command byte |
| xfer_count | output | 16 | Transfer count from indices 1:0 |

## Verification
Read data is combinational from the registers, so the bench samples rdata a quarter period after the falling edge that starts the read strobe, while the strobe is still high. Every effect of a write or a read strobe lands at the single rising edge inside the strobe. Register contents, FIFO level, irq and dma_irq are therefore due one cycle after the strobe begins. The bench compares them only after the strobe has dropped at the next falling edge. Expected read values are queued by the driver before each strobe, and the monitor takes one expected value from the queue for each read strobe it sees.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

  localparam int IDX_W    = 4;
  localparam int NUM_REGS = 1 << IDX_W;

  // register indices whose position drives behaviour
  localparam logic [IDX_W-1:0] REG_CNT_LO = 4'd0;
  localparam logic [IDX_W-1:0] REG_CNT_HI = 4'd1;
  localparam logic [IDX_W-1:0] REG_FIFO   = 4'd2;
  localparam logic [IDX_W-1:0] REG_CMD    = 4'd3;
  localparam logic [IDX_W-1:0] REG_STAT   = 4'd4;
  localparam logic [IDX_W-1:0] REG_INTR   = 4'd5;
  localparam logic [IDX_W-1:0] REG_SEQ    = 4'd6;
  localparam logic [IDX_W-1:0] REG_LOADED = 4'd7;
  localparam logic [IDX_W-1:0] REG_CFG    = 4'd8;
  localparam logic [IDX_W-1:0] REG_ID     = 4'd14;

  localparam int CFG_QUIET_BIT = 6;

  // codes written into the reporting registers
  localparam logic [7:0] ID_VALUE       = 8'h04;
  localparam logic [7:0] INTR_FUNC_DONE = 8'h08;
  localparam logic [7:0] INTR_BUS_SVC   = 8'h10;
  localparam logic [7:0] INTR_BUS_RST   = 8'h80;
  localparam logic [7:0] STAT_TC        = 8'h10;
  localparam logic [7:0] STAT_XFER_DONE = 8'h93;
  localparam logic [7:0] MASK_CFG3      = 8'h15;

  typedef enum logic [6:0] {
    CMD_NOP      = 7'h00,
    CMD_FLUSH    = 7'h01,
    CMD_CHIP_RST = 7'h02,
    CMD_BUS_RST  = 7'h03,
    CMD_XFER     = 7'h10
  } cmd_code_e;

  typedef struct packed {
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic xfer;
    logic dma;
  } cmd_ev_t;

  // which bits of a written byte land in the readable copy
  function automatic logic [7:0] store_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0, 4'd1, 4'd3, 4'd8,
      4'd12, 4'd13, 4'd14, 4'd15: return 8'hFF;
      4'd11:                      return MASK_CFG3;
      default:                    return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] clamp_load(input logic [15:0] req,
                                             input logic [15:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  function automatic logic [7:0] keep_tc(input logic [7:0] stat);
    return stat & STAT_TC;
  endfunction

endpackage

// File: rtl/scsi_regif_fifo.sv
module scsi_regif_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             full, empty, do_push, do_pop;
  logic [CNT_W-1:0] cnt_nxt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clear && !load;
  assign do_pop  = pop && !empty && !clear && !load;
  assign head    = mem[rp];

  always_comb begin
    case ({do_push, do_pop})
      2'b10:   cnt_nxt = count + 1'b1;
      2'b01:   cnt_nxt = count - 1'b1;
      default: cnt_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (load) begin
      wp    <= '0;
      rp    <= '0;
      count <= load_cnt;
    end else begin
      count <= cnt_nxt;
      if (do_pop && cnt_nxt == '0) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (do_push) wp <= ptr_inc(wp);
        if (do_pop)  rp <= ptr_inc(rp);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

endmodule

// File: rtl/scsi_regif_cmd.sv
module scsi_regif_cmd
  import scsi_regif_pkg::*;
(
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output cmd_ev_t          ev
);

  logic      cmd_wr;
  cmd_code_e code;

  assign cmd_wr = wr_en && (idx == REG_CMD);
  assign code   = cmd_code_e'(wdata[6:0]);

  always_comb begin
    ev          = '0;
    ev.dma      = wdata[7];
    if (cmd_wr) begin
      case (code)
        CMD_FLUSH:    ev.flush    = 1'b1;
        CMD_CHIP_RST: ev.chip_rst = 1'b1;
        CMD_BUS_RST:  ev.bus_rst  = 1'b1;
        CMD_XFER:     ev.xfer     = 1'b1;
        default:      ev.flush    = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/scsi_regif_irq.sv
module scsi_regif_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_all,
  input  logic raise_irq,
  input  logic raise_flag,
  input  logic ack,
  output logic irq,
  output logic dma_irq
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      irq     <= 1'b0;
      dma_irq <= 1'b0;
    end else begin
      if (ack) begin
        irq     <= 1'b0;
        dma_irq <= 1'b0;
      end
      if (raise_irq)  irq     <= 1'b1;
      if (raise_flag) dma_irq <= 1'b1;
    end
  end

endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              dma_irq,
  output logic              dma_mode,
  output logic [15:0]       xfer_count
);

  logic [7:0]       bank [NUM_REGS];
  logic [IDX_W-1:0] idx;
  cmd_ev_t          ev;

  // named internal events
  logic             rd_access, rd_pop, rd_ack, wr_push;
  logic             cfg_quiet, bus_rst_loud, nodma_load;
  logic [7:0]       fifo_head, wmask;
  logic [CNT_W-1:0] fifo_count, load_cnt;
  logic [15:0]      clamped;
  logic             unused_bits;

  assign idx          = addr[IDX_W+1:2];
  assign unused_bits  = ^{addr[1:0], clamped};
  assign rd_access    = rd_en && !wr_en;
  assign rd_pop       = rd_access && (idx == REG_FIFO) && (fifo_count != '0);
  assign rd_ack       = rd_access && (idx == REG_INTR);
  assign wr_push      = wr_en && (idx == REG_FIFO);
  assign cfg_quiet    = bank[REG_CFG][CFG_QUIET_BIT];
  assign bus_rst_loud = ev.bus_rst && !cfg_quiet;
  assign nodma_load   = ev.xfer && !ev.dma;
  assign wmask        = store_mask(idx);
  assign clamped      = clamp_load(xfer_count, 16'(DEPTH));
  assign load_cnt     = clamped[CNT_W-1:0];

  assign xfer_count   = {bank[REG_CNT_HI], bank[REG_CNT_LO]};
  assign dma_mode     = bank[REG_CMD][7];

  scsi_regif_cmd u_cmd (
    .wr_en (wr_en),
    .idx   (idx),
    .wdata (wdata),
    .ev    (ev)
  );

  scsi_regif_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev.chip_rst || ev.flush),
    .push     (wr_push),
    .pop      (rd_pop),
    .load     (nodma_load),
    .load_cnt (load_cnt),
    .wdata    (wdata),
    .head     (fifo_head),
    .count    (fifo_count)
  );

  scsi_regif_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_all  (ev.chip_rst),
    .raise_irq  (rd_pop || bus_rst_loud || ev.xfer),
    .raise_flag (bus_rst_loud || (ev.xfer && ev.dma)),
    .ack        (rd_ack),
    .irq        (irq),
    .dma_irq    (dma_irq)
  );

  // read data is combinational; the FIFO slot shows the head while not empty
  always_comb begin
    if (idx == REG_FIFO && fifo_count != '0) rdata = fifo_head;
    else                                     rdata = bank[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ev.chip_rst) begin
      for (int i = 0; i < NUM_REGS; i++)
        bank[i] <= (IDX_W'(i) == REG_ID) ? ID_VALUE : 8'h00;
    end else if (wr_en) begin
      if (wmask != 8'h00) bank[idx] <= wdata & wmask;
      if (ev.flush) begin
        bank[REG_INTR] <= INTR_FUNC_DONE;
        bank[REG_SEQ]  <= 8'h00;
      end
      if (ev.bus_rst) bank[REG_INTR] <= INTR_BUS_RST;
      if (ev.xfer && ev.dma) begin
        bank[REG_STAT] <= STAT_XFER_DONE;
        bank[REG_INTR] <= INTR_BUS_SVC;
        bank[REG_SEQ]  <= 8'h00;
      end
      if (nodma_load) bank[REG_LOADED] <= bank[REG_CNT_LO];
    end else if (rd_access) begin
      if (rd_pop) bank[REG_FIFO] <= fifo_head;
      if (rd_ack) bank[REG_STAT] <= keep_tc(bank[REG_STAT]);
    end
  end

endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              irq,
  input logic              dma_irq,
  input logic              dma_mode,
  input logic [15:0]       xfer_count,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              cfg_quiet
);

  logic [3:0] a_idx;
  logic       cmd_wr;
  assign a_idx  = addr[5:2];
  assign cmd_wr = wr_en && a_idx == 4'd3;

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH)); // R4

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && a_idx == 4'd2 && fifo_count == CNT_W'(DEPTH) |=> fifo_count == CNT_W'(DEPTH)); // R4

  AST_POP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && a_idx == 4'd2 && fifo_count != '0 |=> irq); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && a_idx == 4'd5 |=> !irq && !dma_irq); // R12

  AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[6:0] != 7'h02 |=> dma_mode == $past(wdata[7])); // R6

  AST_QUIET_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[6:0] == 7'h03 && cfg_quiet && !irq |=> !irq); // R9

  AST_CHIP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[6:0] == 7'h02 |=> !irq && !dma_irq && !dma_mode
      && fifo_count == '0 && xfer_count == 16'h0000); // R8

endmodule

bind scsi_regif scsi_regif_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .irq        (irq),
  .dma_irq    (dma_irq),
  .dma_mode   (dma_mode),
  .xfer_count (xfer_count),
  .fifo_count (fifo_count),
  .cfg_quiet  (cfg_quiet)
);

// File: tb/scsi_regif_tb.sv
module scsi_regif_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DEPTH      = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              irq, dma_irq, dma_mode;
  logic [15:0]       xfer_count;

  int vectors     = 0;
  int miscompares = 0;

  typedef struct {
    logic [7:0] exp;
    int         idx;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regif #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq        (irq),
    .dma_irq    (dma_irq),
    .dma_mode   (dma_mode),
    .xfer_count (xfer_count)
  );

  // monitor: one expected value per read strobe
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rd_en) begin
        vectors++;
        if (sb_q.size() == 0) begin
          miscompares++;
          $display("FAIL scoreboard: unexpected read, got %h expected none", rdata);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (rdata !== it.exp) begin
            miscompares++;
            $display("FAIL %s reg %0d: got %h expected %h", it.tag, it.idx, rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = ADDR_W'(idx * 4);
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.idx = idx; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = ADDR_W'(idx * 4);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    #1;
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 dma_irq", 16'(dma_irq), 16'h0);
    chk("R1 dma_mode", 16'(dma_mode), 16'h0);
    rd(14, 8'h04, "R1 id");
    rd(0, 8'h00, "R1 cnt");
    rd(5, 8'h00, "R1 intr");
    rd(2, 8'h00, "R1 empty fifo");

    // R2 transfer count
    wr(0, 8'h34); wr(1, 8'h12);
    rd(0, 8'h34, "R2 lo");
    rd(1, 8'h12, "R2 hi");
    chk("R2 xfer_count", xfer_count, 16'h1234);

    // R13 write masks
    wr(11, 8'hFF); rd(11, 8'h15, "R13 masked");
    wr(8, 8'hA5);  rd(8, 8'hA5, "R13 cfg");
    wr(13, 8'h3C); rd(13, 8'h3C, "R13 plain");
    wr(4, 8'hFF);  rd(4, 8'h00, "R13 stat ro");
    wr(9, 8'h77);  rd(9, 8'h00, "R13 reg9 ro");
    wr(7, 8'h55);  rd(7, 8'h00, "R13 reg7 ro");
    wr(8, 8'h00);

    // R3 / R5 FIFO order and empty read
    wr(2, 8'h11); wr(2, 8'h22); wr(2, 8'h33);
    rd(2, 8'h11, "R3 pop0");
    chk("R3 irq after pop", 16'(irq), 16'h1);
    rd(2, 8'h22, "R3 pop1");
    rd(2, 8'h33, "R3 pop2");
    rd(5, 8'h00, "R12 ack");
    chk("R12 irq cleared", 16'(irq), 16'h0);
    rd(2, 8'h33, "R5 empty repeats last");
    chk("R5 irq unchanged", 16'(irq), 16'h0);

    // R4 full FIFO drops extra push
    for (int i = 0; i < DEPTH; i++) wr(2, 8'(8'h40 + i));
    wr(2, 8'hEE);
    for (int i = 0; i < DEPTH; i++) rd(2, 8'(8'h40 + i), "R4 order");
    rd(2, 8'h4F, "R4 nothing extra");
    rd(5, 8'h00, "R12 ack");

    // R6 DMA mode bit
    wr(3, 8'h80);
    chk("R6 dma_mode set", 16'(dma_mode), 16'h1);
    rd(3, 8'h80, "R6 cmd readback");
    wr(3, 8'h00);
    chk("R6 dma_mode clear", 16'(dma_mode), 16'h0);

    // R7 flush
    wr(2, 8'h71); wr(2, 8'h72);
    wr(3, 8'h01);
    chk("R7 no irq", 16'(irq), 16'h0);
    rd(5, 8'h08, "R7 intr");
    rd(6, 8'h00, "R7 seq");
    rd(2, 8'h4F, "R7 fifo emptied");

    // R14 unknown command
    wr(3, 8'h25);
    rd(3, 8'h25, "R14 cmd stored");
    rd(5, 8'h08, "R14 intr kept");
    rd(7, 8'h00, "R14 reg7 kept");
    chk("R14 irq", 16'(irq), 16'h0);
    wr(3, 8'h9F);
    chk("R14 mode via bit7", 16'(dma_mode), 16'h1);
    rd(5, 8'h08, "R14 intr kept");

    // R10 DMA transfer
    wr(0, 8'h05); wr(1, 8'h00);
    wr(3, 8'h90);
    chk("R10 irq", 16'(irq), 16'h1);
    chk("R10 dma_irq", 16'(dma_irq), 16'h1);
    rd(4, 8'h93, "R10 stat");
    rd(5, 8'h10, "R10 intr");
    chk("R12 irq", 16'(irq), 16'h0);
    chk("R12 dma_irq", 16'(dma_irq), 16'h0);
    rd(4, 8'h10, "R12 stat keeps tc");
    rd(6, 8'h00, "R10 seq");

    // R11 non-DMA transfer loads FIFO level
    wr(2, 8'hA1); wr(2, 8'hB2); wr(2, 8'hC3);
    wr(0, 8'h02);
    wr(3, 8'h10);
    chk("R11 irq", 16'(irq), 16'h1);
    chk("R11 no dma_irq", 16'(dma_irq), 16'h0);
    rd(7, 8'h02, "R11 reg7");
    rd(2, 8'hA1, "R11 pop0");
    rd(2, 8'hB2, "R11 pop1");
    rd(2, 8'hB2, "R11 level two");
    rd(5, 8'h10, "R12 ack");

    // R11 clamp at depth
    wr(3, 8'h01);
    for (int i = 0; i < DEPTH; i++) wr(2, 8'(8'hC0 + i));
    wr(0, 8'h20);
    wr(3, 8'h10);
    for (int i = 0; i < DEPTH; i++) rd(2, 8'(8'hC0 + i), "R11 clamp");
    rd(2, 8'hCF, "R11 clamp end");
    rd(7, 8'h20, "R11 reg7 full count");
    rd(5, 8'h08, "R12 ack");

    // R9 bus reset masked and unmasked
    wr(8, 8'h40);
    wr(3, 8'h03);
    chk("R9 masked irq", 16'(irq), 16'h0);
    chk("R9 masked flag", 16'(dma_irq), 16'h0);
    rd(5, 8'h80, "R9 intr code");
    wr(8, 8'h00);
    wr(3, 8'h03);
    chk("R9 irq", 16'(irq), 16'h1);
    chk("R9 flag", 16'(dma_irq), 16'h1);

    // R8 chip reset (irq still pending)
    wr(0, 8'h12); wr(8, 8'h33); wr(2, 8'h5A);
    wr(3, 8'h82);
    chk("R8 irq", 16'(irq), 16'h0);
    chk("R8 flag", 16'(dma_irq), 16'h0);
    chk("R8 mode", 16'(dma_mode), 16'h0);
    rd(0, 8'h00, "R8 cnt");
    rd(8, 8'h00, "R8 cfg");
    rd(14, 8'h04, "R8 id");
    rd(3, 8'h00, "R8 cmd");
    rd(5, 8'h00, "R8 intr");
    rd(2, 8'h00, "R8 fifo");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule